// File: doc/BRIEF.md
# Cursor and Character Blink Generator

This block produces two visibility levels for a display controller. One gates the text cursor. The other gates characters whose attribute asks for blinking, and it also serves as the pixel blink in graphics mode. Both levels advance only on vertical-sync pulses, so every phase change falls on a frame boundary. Applying the levels to glyphs or pixels is left to the logic downstream.

An 8-bit control word is written through a strobe and held inside the block. The low six bits give the cursor half-period code N. The cursor is visible for N+1 frames and then hidden for N+1 frames. The top two bits pick the character duty cycle. Code 00 uses the cursor period. Every other code doubles the period and shows the character for a quarter, a half or three quarters of it. In graphics mode the register is ignored, and both levels follow a fixed blink of 16 frames on and 16 frames off.

All phases come from one frame counter. Writing the register or changing the mode restarts the counter at the start of the visible phase.

Top module: `blink_gen`

## Requirements
- R1: After reset the control word is 8'h83 (half-period code 3, duty code 2'b10), the frame counter is zero, and both `cursor_on` and `char_on` are 1.
- R2: In text mode, with half-period code N in bits 5:0, `cursor_on` is 1 for frames 0..N of each 2(N+1)-frame cycle and 0 for the rest. Frames are counted in vsync pulses since the last restart.
- R3: In text mode, with duty code 2'b00 in bits 7:6, `char_on` equals `cursor_on` on every frame.
- R4: In text mode, with duty code 2'b01, `char_on` is 1 for the first N+1 frames of each 4(N+1)-frame cycle and 0 otherwise.
- R5: In text mode, with duty code 2'b10, `char_on` is 1 for the first 2(N+1) frames of each 4(N+1)-frame cycle and 0 otherwise.
- R6: In text mode, with duty code 2'b11, `char_on` is 1 for the first 3(N+1) frames of each 4(N+1)-frame cycle and 0 otherwise.
- R7: In graphics mode (`gfx_mode`=1), both outputs are 1 for frames 0..15 of each 32-frame cycle and 0 for frames 16..31, whatever the control word holds.
- R8: A cycle with `cfg_we`=1 loads `cfg_wdata` and restarts the frame count at 0. This holds even when a vsync pulse arrives in the same cycle. Both outputs are 1 two rising edges after the write is sampled.
- R9: A change of `gfx_mode` restarts the frame count at 0, the same way a write does.
- R10: An output changes only on the second rising edge after a vsync pulse, a write or a mode change is sampled. Without these, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync_pulse | input | 1 | One-cycle pulse per frame |
| gfx_mode | input | 1 | 1 selects graphics mode, 0 text mode |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word: bits 7:6 duty code, bits 5:0 half-period code |
| cursor_on | output | 1 | Cursor visible level |
| char_on | output | 1 | Character/pixel blink visible level |

## Verification
The bench runs frame sweeps for every duty code with several half-period codes: the smallest (0), small odd and even values, and the largest (63), so that it wraps the doubled 256-frame cycle. Each sweep compares both outputs frame by frame with a model of the period and duty. A wrong quarter boundary or an undoubled period shows up as a mismatch at a specific frame. A graphics sweep with a short register period separates the fixed 32-frame blink from the register-driven one. Writes in mid-cycle, a write that lands with a vsync, mode toggles and long stretches without vsync show that only the intended events move or restart the phase.

// File: rtl/blink_pkg.sv
package blink_pkg;
  typedef enum logic [1:0] {
    DUTY_EVEN_SHORT = 2'b00,
    DUTY_QUARTER    = 2'b01,
    DUTY_EVEN_LONG  = 2'b10,
    DUTY_THREE_Q    = 2'b11
  } duty_e;

  localparam int         DEF_PERIOD_W  = 6;
  localparam int         DEF_GFX_HALF  = 16;
  localparam int         DEF_HALF_CODE = 3;
  localparam logic [1:0] DEF_DUTY      = 2'b10;
endpackage

// File: rtl/blink_cfg_reg.sv
module blink_cfg_reg
  import blink_pkg::*;
#(
  parameter int PERIOD_W  = DEF_PERIOD_W,
  parameter int HALF_INIT = DEF_HALF_CODE
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [PERIOD_W+1:0]   wdata,
  output logic [PERIOD_W-1:0]   half_code,
  output duty_e                 duty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      half_code <= PERIOD_W'(HALF_INIT);
      duty      <= duty_e'(DEF_DUTY);
    end else if (we) begin
      half_code <= wdata[PERIOD_W-1:0];
      duty      <= duty_e'(wdata[PERIOD_W+1:PERIOD_W]);
    end
  end

  assert_reset_word_R1: assert property (@(posedge clk)
    $past(rst) && !$past(we) |-> half_code == PERIOD_W'(HALF_INIT) && duty == duty_e'(DEF_DUTY))
    else $error("reset control word wrong");
endmodule

// File: rtl/blink_frame_counter.sv
module blink_frame_counter
  import blink_pkg::*;
#(
  parameter int PERIOD_W = DEF_PERIOD_W,
  parameter int GFX_HALF = DEF_GFX_HALF,
  parameter int CNT_W    = PERIOD_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync,
  input  logic                restart,
  input  logic                gfx_q,
  input  logic [PERIOD_W-1:0] half_code,
  input  duty_e               duty,
  output logic [CNT_W-1:0]    cnt
);
  localparam int W1 = CNT_W + 1;

  logic [W1-1:0] half, last, cnt_x;

  always_comb begin
    half  = W1'(half_code) + W1'(1);
    cnt_x = W1'(cnt);
    if (gfx_q)
      last = W1'(2 * GFX_HALF - 1);
    else if (duty == DUTY_EVEN_SHORT)
      last = (half << 1) - W1'(1);
    else
      last = (half << 2) - W1'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (restart)
      cnt <= '0;
    else if (vsync)
      cnt <= (cnt_x >= last) ? '0 : cnt + CNT_W'(1);
  end

  assert_count_in_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_x <= last)
    else $error("frame count beyond cycle end");

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0)
    else $error("restart did not clear count");

  assert_hold_no_vsync_R10: assert property (@(posedge clk) disable iff (rst)
    !vsync && !restart |=> $stable(cnt))
    else $error("count moved without vsync");
endmodule

// File: rtl/blink_phase_decode.sv
module blink_phase_decode
  import blink_pkg::*;
#(
  parameter int PERIOD_W = DEF_PERIOD_W,
  parameter int GFX_HALF = DEF_GFX_HALF,
  parameter int CNT_W    = PERIOD_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                gfx_q,
  input  logic [PERIOD_W-1:0] half_code,
  input  duty_e               duty,
  output logic                cursor_on,
  output logic                char_on
);
  localparam int W1 = CNT_W + 1;

  logic [W1-1:0] half, cnt_x, cur_pos;
  logic          cur_nx, chr_nx;

  always_comb begin
    half    = W1'(half_code) + W1'(1);
    cnt_x   = W1'(cnt);
    cur_pos = (cnt_x >= (half << 1)) ? cnt_x - (half << 1) : cnt_x;
    if (gfx_q) begin
      cur_nx = cnt_x < W1'(GFX_HALF);
      chr_nx = cur_nx;
    end else begin
      cur_nx = cur_pos < half;
      unique case (duty)
        DUTY_EVEN_SHORT: chr_nx = cur_nx;
        DUTY_QUARTER:    chr_nx = cnt_x < half;
        DUTY_EVEN_LONG:  chr_nx = cnt_x < (half << 1);
        DUTY_THREE_Q:    chr_nx = cnt_x < ((half << 1) + half);
        default:         chr_nx = cur_nx;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cursor_on <= 1'b1;
      char_on   <= 1'b1;
    end else begin
      cursor_on <= cur_nx;
      char_on   <= chr_nx;
    end
  end

  assert_short_duty_match_R3: assert property (@(posedge clk) disable iff (rst)
    !gfx_q && duty == DUTY_EVEN_SHORT |=> char_on == cursor_on)
    else $error("00 duty char differs from cursor");

  assert_quarter_inside_cursor_R4: assert property (@(posedge clk) disable iff (rst)
    !gfx_q && duty == DUTY_QUARTER |=> !char_on || cursor_on)
    else $error("quarter duty char on while cursor off");

  assert_three_q_covers_cursor_R6: assert property (@(posedge clk) disable iff (rst)
    !gfx_q && duty == DUTY_THREE_Q |=> !cursor_on || char_on)
    else $error("three-quarter duty char off while cursor on");

  assert_gfx_levels_equal_R7: assert property (@(posedge clk) disable iff (rst)
    gfx_q |=> char_on == cursor_on)
    else $error("graphics levels differ");
endmodule

// File: rtl/blink_gen.sv
module blink_gen
  import blink_pkg::*;
#(
  parameter int PERIOD_W = DEF_PERIOD_W,
  parameter int GFX_HALF = DEF_GFX_HALF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vsync_pulse,
  input  logic                gfx_mode,
  input  logic                cfg_we,
  input  logic [PERIOD_W+1:0] cfg_wdata,
  output logic                cursor_on,
  output logic                char_on
);
  localparam int GFX_W = $clog2(2 * GFX_HALF);
  localparam int CNT_W = (PERIOD_W + 2 > GFX_W) ? PERIOD_W + 2 : GFX_W;

  logic [PERIOD_W-1:0] half_code;
  duty_e               duty;
  logic                gfx_q, restart;
  logic [CNT_W-1:0]    cnt;

  always_ff @(posedge clk) begin
    if (rst) gfx_q <= 1'b0;
    else     gfx_q <= gfx_mode;
  end

  assign restart = cfg_we || (gfx_mode != gfx_q);

  blink_cfg_reg #(.PERIOD_W(PERIOD_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .half_code(half_code), .duty(duty)
  );

  blink_frame_counter #(.PERIOD_W(PERIOD_W), .GFX_HALF(GFX_HALF), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .vsync(vsync_pulse), .restart(restart), .gfx_q(gfx_q),
    .half_code(half_code), .duty(duty), .cnt(cnt)
  );

  blink_phase_decode #(.PERIOD_W(PERIOD_W), .GFX_HALF(GFX_HALF), .CNT_W(CNT_W)) u_dec (
    .clk(clk), .rst(rst), .cnt(cnt), .gfx_q(gfx_q),
    .half_code(half_code), .duty(duty),
    .cursor_on(cursor_on), .char_on(char_on)
  );

  assert_restart_visible_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> ##1 (cursor_on && char_on))
    else $error("outputs not visible after restart");

  assert_mode_change_restart_R9: assert property (@(posedge clk) disable iff (rst)
    gfx_mode != gfx_q |=> cnt == '0)
    else $error("mode change did not restart");
endmodule

// File: tb/tb_blink_gen.sv
`timescale 1ns/1ps
module tb_blink_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync_pulse = 1'b0;
  logic gfx_mode = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic cursor_on, char_on;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  blink_gen dut (
    .clk(clk), .rst(rst), .vsync_pulse(vsync_pulse), .gfx_mode(gfx_mode),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cursor_on(cursor_on), .char_on(char_on)
  );

  function automatic bit exp_cur(int k, int n, bit g);
    if (g) return (k % 32) < 16;
    return (k % (2 * (n + 1))) < (n + 1);
  endfunction

  function automatic bit exp_chr(int k, int n, int d, bit g);
    int h, q;
    if (g) return (k % 32) < 16;
    h = n + 1;
    if (d == 0) return (k % (2 * h)) < h;
    q = k % (4 * h);
    if (d == 1) return q < h;
    if (d == 2) return q < 2 * h;
    return q < 3 * h;
  endfunction

  task automatic check_bit(logic act, logic exp, string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic vsync_once();
    vsync_pulse = 1'b1;
    @(negedge clk);
    vsync_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_cfg(logic [1:0] d, logic [5:0] n, bit with_vsync);
    cfg_we = 1'b1;
    cfg_wdata = {d, n};
    vsync_pulse = with_vsync;
    @(negedge clk);
    cfg_we = 1'b0;
    vsync_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(bit g);
    gfx_mode = g;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(int n, int d, bit g, int frames, string rc, string rh);
    for (int k = 0; k < frames; k++) begin
      check_bit(cursor_on, exp_cur(k, n, g), rc);
      check_bit(char_on, exp_chr(k, n, d, g), rh);
      vsync_once();
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_bit(cursor_on, 1'b1, "R1 cursor after reset");
    check_bit(char_on, 1'b1, "R1 char after reset");
    sweep(3, 2, 0, 20, "R1/R2 default cursor", "R1/R5 default char");
  endtask

  task automatic t_short_duty();
    write_cfg(2'b00, 6'd0, 0);
    sweep(0, 0, 0, 8, "R2 n0", "R3 n0");
    write_cfg(2'b00, 6'd4, 0);
    sweep(4, 0, 0, 24, "R2 n4", "R3 n4");
  endtask

  task automatic t_quarter();
    write_cfg(2'b01, 6'd5, 0);
    sweep(5, 1, 0, 52, "R2 n5", "R4 n5");
    write_cfg(2'b01, 6'd0, 0);
    sweep(0, 1, 0, 10, "R2 n0", "R4 n0");
  endtask

  task automatic t_half_long();
    write_cfg(2'b10, 6'd1, 0);
    sweep(1, 2, 0, 20, "R2 n1", "R5 n1");
  endtask

  task automatic t_three_q();
    write_cfg(2'b11, 6'd2, 0);
    sweep(2, 3, 0, 28, "R2 n2", "R6 n2");
    write_cfg(2'b11, 6'd63, 0);
    sweep(63, 3, 0, 300, "R2 n63", "R6 n63");
  endtask

  task automatic t_graphics();
    write_cfg(2'b01, 6'd1, 0);
    repeat (3) vsync_once();
    set_mode(1);
    check_bit(cursor_on, 1'b1, "R9 cursor after mode change");
    sweep(1, 1, 1, 70, "R7 gfx cursor", "R7 gfx char");
    set_mode(0);
    sweep(1, 1, 0, 9, "R9 back to text cursor", "R9 back to text char");
  endtask

  task automatic t_restart_mid();
    write_cfg(2'b10, 6'd3, 0);
    repeat (5) vsync_once();
    check_bit(cursor_on, 1'b0, "R2 mid cycle cursor off");
    write_cfg(2'b10, 6'd3, 0);
    check_bit(cursor_on, 1'b1, "R8 cursor after rewrite");
    check_bit(char_on, 1'b1, "R8 char after rewrite");
    repeat (6) vsync_once();
    write_cfg(2'b11, 6'd2, 1);
    sweep(2, 3, 0, 10, "R8 write with vsync cursor", "R8 write with vsync char");
  endtask

  task automatic t_hold();
    write_cfg(2'b10, 6'd3, 0);
    repeat (5) vsync_once();
    for (int c = 0; c < 40; c++) begin
      check_bit(cursor_on, 1'b0, "R10 cursor held");
      check_bit(char_on, 1'b1, "R10 char held");
      @(negedge clk);
    end
    vsync_once();
    check_bit(cursor_on, 1'b0, "R10 cursor after vsync frame 6");
    repeat (2) vsync_once();
    check_bit(char_on, 1'b0, "R10 char off at frame 8");
    check_bit(cursor_on, 1'b1, "R10 cursor on at frame 8");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_short_duty();
    t_quarter();
    t_half_long();
    t_three_q();
    t_graphics();
    t_restart_mid();
    t_hold();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule